// File: doc/BRIEF.md
# Frame-Paced Serial Audio Transmitter

This block accepts a burst of PCM audio samples during each 1 ms bus frame and plays them out evenly spaced over the following frame. It places each stereo sample on a three-wire serial audio link: bit clock, word select and serial data. The block drives all three wires itself. A frame tick, locked to the bus start-of-frame marker, marks each frame boundary. Samples come in through a simple write port into a pair buffer. Each sample word may be 8, 16 or 24 bits wide, in mono or stereo.

The spacing comes from the number of stereo pairs received in the previous frame. A fractional accumulator adds that count every clock and emits a release each time it crosses the number of clocks in a frame. Each release plays one stereo pair as a gated burst of 64 bit clocks, in two 32-bit slots. The output format is chosen by a select input: standard I2S, or LSB-justified with a 16, 18 or 20 bit word. If a release finds the buffer empty, the block repeats the last pair and raises a sticky flag.

Top module: `frame_paced_audio_tx`

## Requirements
- R1: While reset is asserted, and afterwards until the first release, `bclk`, `ws`, `sd` and `underrun` are all low.
- R2: The number of stereo pairs written between two frame ticks is the number of bursts played after the second tick, and none is played before it. Each burst is 64 bit-clock periods long.
- R3: Within a frame that plays n pairs, consecutive bursts start either floor(P/n) or floor(P/n)+1 clocks apart, where P is `CLK_PER_FRAME`.
- R4: `out_fmt` selects the format: 0 = I2S, 1 = LSB-justified 16, 2 = LSB-justified 18, 3 = LSB-justified 20. Bit k of a burst (0..63) is sampled on the k-th rising bit-clock edge. Bits 0..31 form the left slot and bits 32..63 the right slot. In I2S, `ws` is high for bits 31..62. In LSB-justified modes, `ws` is high for bits 32..63.
- R5: In I2S, the 24-bit left-aligned left word appears MSB first on bits 1..24, and the right word on bits 33..56. All other bits are 0.
- R6: In LSB-justified mode with width W, each slot ends with the top W bits of the channel word, MSB first, with their LSB on the slot's last bit. Every bit before them repeats bit 23 of the word.
- R7: `in_width` selects the input width: 0 = 8 bits in `wr_data[7:0]`, 1 = 16 bits in `wr_data[15:0]`, 2 or 3 = 24 bits. Narrower words are left-aligned into 24 bits, and the unused upper input bits are ignored.
- R8: With `in_stereo` high, writes alternate left then right, and each completed pair is stored. With it low, each write forms a pair that carries the same word on both channels.
- R9: A release that finds the buffer empty replays the last played pair and sets `underrun`, which stays high until reset. Writes that arrive while the buffer is full are dropped, but they still count toward the next frame's release count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse at each 1 ms frame start |
| wr_en | input | 1 | Sample word write strobe |
| wr_data | input | 24 | Sample word, right-aligned at its input width |
| in_width | input | 2 | Input word width code |
| in_stereo | input | 1 | 1: stereo alternate writes, 0: mono |
| out_fmt | input | 2 | Serial output format code |
| bclk | output | 1 | Serial bit clock (gated per burst) |
| ws | output | 1 | Word select |
| sd | output | 1 | Serial data |
| underrun | output | 1 | Sticky buffer underrun flag |

## Verification
The hardest state to reach from the ports is a release that finds the buffer empty. The count per frame normally matches the buffer contents exactly, so this never happens in ordinary use. To reach it, the stimulus first runs a frame with no writes, which leaves the buffer empty. It then writes more pairs in one frame than the buffer holds. The extra pairs are dropped but still counted, so the last releases of the following frame find the buffer empty. The bench checks that those bursts repeat the last stored pair and that the flag rises only then. The same run covers the densest burst spacing and all four output formats, each on its own frame.

// File: rtl/fpat_pkg.sv
package fpat_pkg;
  localparam int SW = 24;

  typedef enum logic [1:0] {
    FMT_I2S   = 2'd0,
    FMT_LSB16 = 2'd1,
    FMT_LSB18 = 2'd2,
    FMT_LSB20 = 2'd3
  } ser_fmt_e;

  typedef enum logic [1:0] {
    IW_8   = 2'd0,
    IW_16  = 2'd1,
    IW_24  = 2'd2,
    IW_24B = 2'd3
  } in_width_e;

  typedef struct packed {
    logic [SW-1:0] l;
    logic [SW-1:0] r;
  } pair_t;
endpackage

// File: rtl/fpat_packer.sv
module fpat_packer
  import fpat_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  input  logic [1:0]    in_width,
  input  logic          in_stereo,
  output logic          push_o,
  output pair_t         pair_o
);
  logic [SW-1:0] aligned;
  logic          have_left_q, have_left_d;
  logic [SW-1:0] left_q, left_d;
  logic          push_d;
  pair_t         pair_d;

  always_comb begin
    case (in_width_e'(in_width))
      IW_8:    aligned = {wr_data[7:0], 16'h0000};
      IW_16:   aligned = {wr_data[15:0], 8'h00};
      default: aligned = wr_data;
    endcase
    push_d      = wr_en && (!in_stereo || have_left_q);
    pair_d      = in_stereo ? pair_t'{l: left_q, r: aligned} : pair_t'{l: aligned, r: aligned};
    left_d      = (wr_en && in_stereo && !have_left_q) ? aligned : left_q;
    have_left_d = in_stereo ? (have_left_q ^ wr_en) : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_left_q <= 1'b0;
      left_q      <= '0;
      push_o      <= 1'b0;
      pair_o      <= '0;
    end else begin
      have_left_q <= have_left_d;
      left_q      <= left_d;
      push_o      <= push_d;
      if (push_d) pair_o <= pair_d;
    end
  end

  // a mono pair always carries one word on both channels
  p_mono_dup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && !$past(in_stereo)) |-> (push_o && pair_o.l == pair_o.r));
endmodule

// File: rtl/fpat_fifo.sv
module fpat_fifo
  import fpat_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  pair_t din,
  input  logic  pop,
  output pair_t dout,
  output logic  empty,
  output logic  full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   FULLC = (AW+1)'(DEPTH);

  pair_t         mem [DEPTH];
  logic [AW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic          do_wr, do_rd;

  always_comb begin
    empty = (cnt_q == '0);
    full  = (cnt_q == FULLC);
    do_wr = push && !full;
    do_rd = pop && !empty;
    wp_d  = do_wr ? ((wp_q == LAST) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d  = do_rd ? ((rp_q == LAST) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_d = cnt_q + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    dout  = mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  // a write into a full buffer leaves its occupancy unchanged unless read
  p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
endmodule

// File: rtl/fpat_pacer.sv
module fpat_pacer #(
  parameter int FRAME_CLKS = 24576,
  parameter int CNT_W      = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic pair_push,
  output logic release_o
);
  localparam int ACC_W = $clog2(FRAME_CLKS) + 2;
  localparam logic [ACC_W-1:0] FRAME_C = ACC_W'(FRAME_CLKS);

  logic [CNT_W-1:0] cnt_q, cnt_d, rate_q, rate_d;
  logic [ACC_W-1:0] acc_q, acc_d, sum;

  always_comb begin
    sum       = acc_q + ACC_W'(rate_q);
    release_o = (rate_q != '0) && (sum >= FRAME_C);
    cnt_d     = cnt_q + CNT_W'(pair_push);
    rate_d    = rate_q;
    acc_d     = acc_q;
    if (rate_q != '0) acc_d = release_o ? (sum - FRAME_C) : sum;
    if (frame_tick) begin
      cnt_d  = CNT_W'(pair_push);
      rate_d = cnt_q;
      acc_d  = FRAME_C - ACC_W'(cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rate_q <= '0;
      acc_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      rate_q <= rate_d;
      acc_q  <= acc_d;
    end
  end

  // releases never come back to back while the count is below the frame length
  p_release_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o && !frame_tick) |=> !release_o);
endmodule

// File: rtl/fpat_serializer.sv
module fpat_serializer
  import fpat_pkg::*;
#(
  parameter int BCLK_HALF = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  pair_t      pair_i,
  input  logic [1:0] fmt_i,
  output logic       busy_o,
  output logic       bclk_o,
  output logic       ws_o,
  output logic       sd_o
);
  localparam int HCW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam logic [HCW-1:0] HLAST = HCW'(BCLK_HALF - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} st_e;

  st_e        st_q, st_d;
  logic [5:0] k_q, k_d;
  logic [HCW-1:0] h_q, h_d;
  pair_t      pair_q, pair_d;
  ser_fmt_e   fmt_q, fmt_d;
  logic       bclk_d, ws_d, sd_d;

  function automatic logic bit_at(input logic [5:0] k, input pair_t p, input ser_fmt_e f);
    logic [SW-1:0] ch;
    int pos, w, idx;
    logic b;
    ch  = k[5] ? p.r : p.l;
    pos = int'(k[4:0]);
    b   = 1'b0;
    if (f == FMT_I2S) begin
      idx = 24 - pos;
      if (pos >= 1 && pos <= 24) b = ch[idx[4:0]];
    end else begin
      w = (f == FMT_LSB16) ? 16 : (f == FMT_LSB18) ? 18 : 20;
      idx = 24 - w + 31 - pos;
      b = (pos < 32 - w) ? ch[SW-1] : ch[idx[4:0]];
    end
    return b;
  endfunction

  function automatic logic ws_at(input logic [5:0] k, input ser_fmt_e f);
    return (f == FMT_I2S) ? (k >= 6'd31 && k <= 6'd62) : k[5];
  endfunction

  always_comb begin
    st_d = st_q; k_d = k_q; h_d = h_q; pair_d = pair_q; fmt_d = fmt_q;
    bclk_d = bclk_o; ws_d = ws_o; sd_d = sd_o;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d = ST_LOW; k_d = '0; h_d = '0;
        pair_d = pair_i; fmt_d = ser_fmt_e'(fmt_i);
        bclk_d = 1'b0;
        ws_d = ws_at(6'd0, ser_fmt_e'(fmt_i));
        sd_d = bit_at(6'd0, pair_i, ser_fmt_e'(fmt_i));
      end
      ST_LOW: begin
        if (h_q == HLAST) begin st_d = ST_HIGH; h_d = '0; bclk_d = 1'b1; end
        else h_d = h_q + 1'b1;
      end
      default: begin
        if (h_q != HLAST) h_d = h_q + 1'b1;
        else if (k_q == 6'd63) begin
          st_d = ST_IDLE; h_d = '0; bclk_d = 1'b0; ws_d = 1'b0; sd_d = 1'b0;
        end else begin
          st_d = ST_LOW; h_d = '0; k_d = k_q + 1'b1; bclk_d = 1'b0;
          ws_d = ws_at(k_q + 1'b1, fmt_q);
          sd_d = bit_at(k_q + 1'b1, pair_q, fmt_q);
        end
      end
    endcase
    busy_o = (st_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; k_q <= '0; h_q <= '0; pair_q <= '0; fmt_q <= FMT_I2S;
      bclk_o <= 1'b0; ws_o <= 1'b0; sd_o <= 1'b0;
    end else begin
      st_q <= st_d; k_q <= k_d; h_q <= h_d; pair_q <= pair_d; fmt_q <= fmt_d;
      bclk_o <= bclk_d; ws_o <= ws_d; sd_o <= sd_d;
    end
  end

  // word select only moves while the bit clock is low
  p_ws_on_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws_o) |-> !bclk_o);
  // the bit clock is gated off between bursts
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> (!bclk_o && !ws_o && !sd_o));
endmodule

// File: rtl/frame_paced_audio_tx.sv
module frame_paced_audio_tx
  import fpat_pkg::*;
#(
  parameter int CLK_PER_FRAME = 24576,
  parameter int BCLK_HALF     = 1,
  parameter int DEPTH         = 64,
  parameter int CNT_W         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          wr_en,
  input  logic [23:0]   wr_data,
  input  logic [1:0]    in_width,
  input  logic          in_stereo,
  input  logic [1:0]    out_fmt,
  output logic          bclk,
  output logic          ws,
  output logic          sd,
  output logic          underrun
);
  logic  push, rel, busy, start, empty, full, pend_q, pend_d, und_d;
  pair_t push_pair, fifo_dout, ser_pair, last_q, last_d;

  fpat_packer u_packer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .in_width(in_width), .in_stereo(in_stereo), .push_o(push), .pair_o(push_pair)
  );

  fpat_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .din(push_pair),
    .pop(start), .dout(fifo_dout), .empty(empty), .full(full)
  );

  fpat_pacer #(.FRAME_CLKS(CLK_PER_FRAME), .CNT_W(CNT_W)) u_pacer (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
    .pair_push(push), .release_o(rel)
  );

  fpat_serializer #(.BCLK_HALF(BCLK_HALF)) u_ser (
    .clk(clk), .rst_n(rst_n), .start(start), .pair_i(ser_pair), .fmt_i(out_fmt),
    .busy_o(busy), .bclk_o(bclk), .ws_o(ws), .sd_o(sd)
  );

  always_comb begin
    start    = pend_q && !busy;
    ser_pair = empty ? last_q : fifo_dout;
    pend_d   = rel || (pend_q && !start);
    last_d   = start ? ser_pair : last_q;
    und_d    = underrun || (start && empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      last_q   <= '0;
      underrun <= 1'b0;
    end else begin
      pend_q   <= pend_d;
      last_q   <= last_d;
      underrun <= und_d;
    end
  end

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  p_underrun_on_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && empty) |=> underrun);
  // a burst starts only from an idle serializer, so bit clock is low then
  p_start_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !bclk);
endmodule

// File: tb/frame_paced_audio_tx_tb_top.sv
module frame_paced_audio_tx_tb_top;
  localparam int P  = 9000;
  localparam int WD = 150000;

  logic clk, rst_n, frame_tick, wr_en, in_stereo;
  logic [23:0] wr_data;
  logic [1:0]  in_width, out_fmt;
  logic bclk, ws, sd, underrun;

  typedef struct {
    logic [23:0] l, r;
    logic [1:0]  fmt;
    int          frame, idx, n;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int tests, fails, frame_no, cyc;
  logic [1:0] rel_fmt [0:9];
  logic [31:0] seed;
  bit done;

  frame_paced_audio_tx #(.CLK_PER_FRAME(P), .BCLK_HALF(1), .DEPTH(64), .CNT_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .wr_en(wr_en), .wr_data(wr_data),
    .in_width(in_width), .in_stereo(in_stereo), .out_fmt(out_fmt),
    .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:8];
  endfunction

  function automatic logic [23:0] align(input logic [23:0] d, input logic [1:0] iw);
    if (iw == 2'd0) return {d[7:0], 16'h0};
    if (iw == 2'd1) return {d[15:0], 8'h0};
    return d;
  endfunction

  function automatic logic [63:0] exp_sd(input exp_t e);
    logic [63:0] v;
    v = '0;
    for (int k = 0; k < 64; k++) begin
      logic [23:0] ch;
      int p, w;
      ch = (k >= 32) ? e.r : e.l;
      p = k % 32;
      if (e.fmt == 2'd0) v[k] = (p >= 1 && p <= 24) ? ch[24 - p] : 1'b0;
      else begin
        w = 16 + 2 * (int'(e.fmt) - 1);
        v[k] = (p < 32 - w) ? ch[23] : ch[24 - w + 31 - p];
      end
    end
    return v;
  endfunction

  function automatic logic [63:0] exp_ws(input logic [1:0] f);
    logic [63:0] v;
    for (int k = 0; k < 64; k++) v[k] = (f == 2'd0) ? (k >= 31 && k <= 62) : (k >= 32);
    return v;
  endfunction

  task automatic wr(input logic [23:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = rnd();
  endtask

  // driver: writes n pairs in frame f, queues what frame f+1 must play
  task automatic write_frame(input int f, input int n, input logic [1:0] iw,
                             input bit st, input string tag);
    logic [23:0] ll, rr;
    in_width = iw; in_stereo = st;
    ll = '0; rr = '0;
    for (int i = 0; i < n; i++) begin
      logic [23:0] a, b;
      a = rnd(); b = st ? rnd() : a;
      wr(a);
      if (st) wr(b);
      if (i < 64) begin
        ll = align(a, iw); rr = align(b, iw);
      end
      sb_q.push_back('{l: ll, r: rr, fmt: rel_fmt[f+1], frame: f + 1, idx: i, n: n, tag: tag});
    end
  endtask

  // frame tick generator
  initial begin
    frame_tick = 1'b0; frame_no = 0; out_fmt = 2'd0;
    wait (rst_n);
    repeat (4) @(negedge clk);
    forever begin
      @(negedge clk);
      frame_tick = 1'b1;
      out_fmt = rel_fmt[(frame_no + 1 > 9) ? 9 : frame_no + 1];
      frame_no++;
      @(negedge clk);
      frame_tick = 1'b0;
      repeat (P - 2) @(negedge clk);
    end
  end

  // monitor / scoreboard
  initial begin
    int prev_start;
    prev_start = 0;
    forever begin
      logic [63:0] got_sd, got_ws;
      exp_t e;
      int t0;
      @(posedge bclk);
      t0 = cyc;
      got_sd[0] = sd; got_ws[0] = ws;
      for (int k = 1; k < 64; k++) begin
        @(posedge bclk);
        got_sd[k] = sd; got_ws[k] = ws;
      end
      if (sb_q.size() == 0) begin
        check(1'b0, "R2 unexpected burst", 64'(frame_no), 64'hFFFF);
      end else begin
        e = sb_q.pop_front();
        check(frame_no == e.frame, "R2 burst frame", 64'(frame_no), 64'(e.frame));
        check(got_ws == exp_ws(e.fmt), "R4 word select", got_ws, exp_ws(e.fmt));
        check(got_sd == exp_sd(e), e.tag, got_sd, exp_sd(e));
        if (e.idx > 0) begin
          int d;
          d = t0 - prev_start;
          check(d == P / e.n || d == P / e.n + 1, "R3 spacing", 64'(d), 64'(P / e.n));
        end
      end
      prev_start = t0;
    end
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", sb_q.size(), 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; cyc = 0; seed = 32'h1234_5678; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; in_width = 2'd2; in_stereo = 1'b1;
    for (int i = 0; i < 10; i++) rel_fmt[i] = 2'd0;
    rel_fmt[3] = 2'd1; rel_fmt[4] = 2'd2; rel_fmt[5] = 2'd3; rel_fmt[7] = 2'd0;
    repeat (5) @(negedge clk);
    check({bclk, ws, sd, underrun} == 4'b0, "R1 reset outputs", 64'({bclk, ws, sd, underrun}), 0);
    rst_n = 1'b1;
    wait (frame_no == 1);
    check({bclk, ws, sd, underrun} == 4'b0, "R1 quiet before release", 64'({bclk, ws, sd, underrun}), 0);
    repeat (4) @(negedge clk);
    write_frame(1, 4, 2'd2, 1'b1, "R5 stereo 24");            // R5 R8
    wait (frame_no == 2); repeat (4) @(negedge clk);
    write_frame(2, 3, 2'd0, 1'b0, "R6 R7 R8 mono 8");
    wait (frame_no == 3); repeat (4) @(negedge clk);
    write_frame(3, 5, 2'd1, 1'b1, "R6 R7 stereo 16");
    wait (frame_no == 4); repeat (4) @(negedge clk);
    write_frame(4, 56, 2'd2, 1'b1, "R6 full rate");
    wait (frame_no == 6); repeat (4) @(negedge clk);
    write_frame(6, 66, 2'd3, 1'b1, "R5 R9 overflow");
    wait (frame_no == 7);
    check(underrun == 1'b0, "R9 no early underrun", 64'(underrun), 0);
    wait (frame_no == 8);
    repeat (10) @(negedge clk);
    check(sb_q.size() == 0, "R2 all pairs played", 64'(sb_q.size()), 0);
    check(underrun == 1'b1, "R9 sticky underrun", 64'(underrun), 1);
    check({bclk, ws, sd} == 3'b0, "R4 idle link", 64'({bclk, ws, sd}), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule